// File: doc/BRIEF.md
# Oversampling Serial Receiver with Status Flags

This block receives asynchronous serial characters on a single line that idles high. It runs from a clock at sixteen times the bit rate. It passes the line through a two-stage synchronizer and detects a falling edge. Eight clocks later it confirms the start bit at its centre. It then samples each further bit sixteen clocks after the one before, which keeps every sample near the middle of its bit cell.

The character format is captured from static inputs while a load strobe is high, and it is held while the strobe is low. The format covers the data length (five to eight bits), whether a parity bit is present, and the parity sense. When the stop bit has been sampled, the assembled character goes into a holding register together with the parity, framing and overrun results, and a data-ready flag rises. The host acknowledges a character by pulling an active-low clear input low for a clock.

Top module: `ovs_serial_rx`

## Requirements
- R1: While `rst` is high and after it falls, `rx_data` is zero, all four status flags are low and the receiver waits for a start edge.
- R2: A clock edge with `fmt_load` high captures `len_sel` (code 0,1,2,3 selects 5,6,7,8 data bits), `par_off` and `par_even`. With `fmt_load` low, changes on those inputs have no effect on how the next character is received.
- R3: If the synchronized line is low when first seen and is high again 8 clocks later, the receiver treats it as a false start, returns to waiting, and no character is delivered.
- R4: Data bits arrive least significant first, and each is sampled 16 clocks after the previous sample. `rx_data` holds the character right-aligned, and the bits above the selected length read as zero.
- R5: With parity enabled, `parity_err` is set with a character whose data bits plus parity bit hold an odd count of ones when `par_even` is 1, or an even count when `par_even` is 0. It is cleared with a character that matches.
- R6: With `par_off` high, no parity bit is expected: the stop bit directly follows the data, and `parity_err` is low for that character.
- R7: `frame_err` is set with a character whose stop-bit sample is low, and cleared with a character whose stop-bit sample is high.
- R8: `data_rdy` rises when a character is transferred, and falls on the clock after `dr_clr_n` is sampled low, unless a transfer occurs in that same cycle.
- R9: `overrun` is set when a character is transferred while `data_rdy` is still high and not being cleared in that cycle. Otherwise a transfer leaves `overrun` low.
- R10: `rx_data`, `overrun`, `frame_err` and `parity_err` change only when a character is transferred. Clearing `data_rdy` leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, 16 times the bit rate |
| rst | input | 1 | Master reset, active high, synchronous |
| ser_in | input | 1 | Serial line, high when idle |
| fmt_load | input | 1 | Format capture strobe, active high |
| len_sel | input | 2 | Data length code, 0..3 selects 5..8 bits |
| par_off | input | 1 | High removes the parity bit from the frame |
| par_even | input | 1 | High selects even parity, low selects odd |
| dr_clr_n | input | 1 | Active-low clear of data-ready |
| rx_data | output | 8 | Last received character, right-aligned |
| data_rdy | output | 1 | A character waits to be read |
| overrun | output | 1 | A character replaced an unread one |
| frame_err | output | 1 | Stop bit of the last character was low |
| parity_err | output | 1 | Parity of the last character was wrong |

## Verification
The assertions assume that format loads happen only while the line is idle between characters. They also assume that the line changes no faster than once per sixteen clocks inside a character, so the sample point always lands within a stable bit cell. The stimulus keeps to both assumptions. It drives each bit for exactly sixteen clock cycles, loads the format only after a frame and its idle gap have finished, and tests the false-start case with a low pulse shorter than half a bit. Overrun and clear are exercised with acknowledgements placed well away from the stop-bit sample, so a clear never coincides with a transfer.

// File: rtl/ovs_serial_rx.sv
module ovs_serial_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ser_in,
  input  logic       fmt_load,
  input  logic [1:0] len_sel,
  input  logic       par_off,
  input  logic       par_even,
  input  logic       dr_clr_n,
  output logic [7:0] rx_data,
  output logic       data_rdy,
  output logic       overrun,
  output logic       frame_err,
  output logic       parity_err
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [1:0]    sync;
  logic [1:0]    f_len;
  logic          f_off, f_even;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          xr;

  wire       rxs     = sync[1];
  wire       tick    = (cnt == FULL);
  wire [2:0] last    = {1'b1, f_len};
  wire [2:0] gap     = 3'd3 - {1'b0, f_len};
  wire [7:0] mask    = 8'hFF >> gap;
  wire [7:0] aligned = sh >> gap;
  wire       xfer    = (st == S_STOP) && tick;

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], ser_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_len  <= 2'd3;
      f_off  <= 1'b1;
      f_even <= 1'b0;
    end else if (fmt_load) begin
      f_len  <= len_sel;
      f_off  <= par_off;
      f_even <= par_even;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      bitn       <= '0;
      sh         <= '0;
      xr         <= 1'b0;
      rx_data    <= '0;
      data_rdy   <= 1'b0;
      overrun    <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      if (!dr_clr_n) data_rdy <= 1'b0;
      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (!rxs) st <= S_START;
        end
        S_START: begin
          if (cnt == HALF) begin
            cnt <= '0;
            bitn <= '0;
            xr   <= 1'b0;
            st   <= rxs ? S_IDLE : S_DATA;
          end
        end
        S_DATA: begin
          if (tick) begin
            sh   <= {rxs, sh[7:1]};
            xr   <= xr ^ rxs;
            bitn <= bitn + 1'b1;
            if (bitn == last) st <= f_off ? S_STOP : S_PAR;
          end
        end
        S_PAR: begin
          if (tick) begin
            xr <= xr ^ rxs;
            st <= S_STOP;
          end
        end
        S_STOP: begin
          if (tick) begin
            rx_data    <= aligned;
            data_rdy   <= 1'b1;
            overrun    <= data_rdy & dr_clr_n;
            frame_err  <= ~rxs;
            parity_err <= ~f_off & (xr ^ ~f_even);
            st         <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) $past(rst) |-> (st == S_IDLE && !data_rdy && !overrun));

  p_stay_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && rxs) |=> (st == S_IDLE));

  p_false_start_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_START && cnt == HALF && rxs) |=> (st == S_IDLE));

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    xfer |=> ((rx_data & ~$past(mask)) == 8'h00));

  p_no_parity_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer && f_off) |=> !parity_err);

  p_set_rdy_r8: assert property (@(posedge clk) disable iff (rst)
    xfer |=> data_rdy);

  p_clear_rdy_r8: assert property (@(posedge clk) disable iff (rst)
    (!dr_clr_n && !xfer) |=> !data_rdy);

  p_overrun_r9: assert property (@(posedge clk) disable iff (rst)
    (xfer && data_rdy && dr_clr_n) |=> overrun);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> ($stable(rx_data) && $stable(overrun) && $stable(frame_err) && $stable(parity_err)));
endmodule

// File: tb/ovs_serial_rx_test.sv
`timescale 1ns/1ps
module ovs_serial_rx_test;
  logic       clk = 1'b0, rst = 1'b1, ser_in = 1'b1, fmt_load = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic       par_off = 1'b1, par_even = 1'b0, dr_clr_n = 1'b1;
  logic [7:0] rx_data;
  logic       data_rdy, overrun, frame_err, parity_err;
  int         errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  ovs_serial_rx uut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .fmt_load(fmt_load), .len_sel(len_sel),
    .par_off(par_off), .par_even(par_even), .dr_clr_n(dr_clr_n), .rx_data(rx_data),
    .data_rdy(data_rdy), .overrun(overrun), .frame_err(frame_err), .parity_err(parity_err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic hold_line(input logic v, input int n);
    ser_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic load_fmt(input int nbits, input logic off, input logic even);
    @(negedge clk);
    len_sel = 2'(nbits - 5); par_off = off; par_even = even; fmt_load = 1'b1;
    @(negedge clk);
    fmt_load = 1'b0;
    len_sel = ~len_sel; par_off = ~off; par_even = ~even;
  endtask

  task automatic send(input logic [7:0] d, input int nbits, input logic off, input logic even,
                      input logic badp, input logic bads);
    logic p;
    p = ^(d & (8'hFF >> (8 - nbits)));
    if (!even) p = ~p;
    hold_line(1'b0, 16);
    for (int i = 0; i < nbits; i++) hold_line(d[i], 16);
    if (!off) hold_line(p ^ badp, 16);
    hold_line(~bads, 16);
    hold_line(1'b1, 10);
  endtask

  task automatic clear_rdy();
    @(negedge clk); dr_clr_n = 1'b0;
    @(negedge clk); dr_clr_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  initial begin
    logic [7:0] pats [6];
    logic [7:0] keep;
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C, 8'h81};
    repeat (4) @(negedge clk);
    chk("R1 data", rx_data, 0);
    chk("R1 flags", {data_rdy, overrun, frame_err, parity_err}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 after release", {rx_data, data_rdy, overrun, frame_err, parity_err}, 0);

    for (int n = 5; n <= 8; n++)
      for (int m = 0; m < 3; m++)
        for (int k = 0; k < 6; k++) begin
          logic off, even;
          off = (m == 0); even = (m == 1);
          load_fmt(n, off, even);
          send(pats[k], n, off, even, 1'b0, 1'b0);
          chk("R4 data", rx_data, pats[k] & (8'hFF >> (8 - n)));
          chk("R8 ready", data_rdy, 1);
          chk("R5 R6 parity ok", parity_err, 0);
          chk("R7 stop ok", frame_err, 0);
          chk("R9 no overrun", overrun, 0);
          clear_rdy();
          @(negedge clk);
          chk("R8 cleared", data_rdy, 0);
          if (!off) begin
            send(pats[k] ^ 8'h13, n, off, even, 1'b1, 1'b0);
            chk("R5 parity bad", parity_err, 1);
            clear_rdy();
          end else begin
            send(pats[k], n, off, even, 1'b1, 1'b0);
            chk("R6 inhibit", parity_err, 0);
            clear_rdy();
          end
          send(pats[k], n, off, even, 1'b0, 1'b1);
          chk("R7 stop low", frame_err, 1);
          chk("R7 data kept", rx_data, pats[k] & (8'hFF >> (8 - n)));
          clear_rdy();
        end

    // R2: format held while strobe is low
    load_fmt(6, 1'b0, 1'b1);
    len_sel = 2'd3; par_off = 1'b1;
    send(8'h2B, 6, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 latched length", rx_data, 8'h2B);
    chk("R2 latched parity", parity_err, 0);
    keep = rx_data;
    clear_rdy();
    @(negedge clk);
    chk("R10 data after clear", rx_data, keep);

    // R3: short low pulse is a false start
    hold_line(1'b0, 4);
    hold_line(1'b1, 60);
    chk("R3 false start", data_rdy, 0);
    chk("R3 data untouched", rx_data, keep);
    send(8'h15, 6, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 next frame", rx_data, 8'h15);

    // R9: second character before clear
    send(8'h0A, 6, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 overrun set", overrun, 1);
    chk("R9 newest data", rx_data, 8'h0A);
    clear_rdy();
    @(negedge clk);
    chk("R10 overrun held", overrun, 1);
    send(8'h31, 6, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 overrun cleared", overrun, 0);

    // R1: reset mid-stream
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 reset again", {rx_data, data_rdy, overrun, frame_err, parity_err}, 0);
    summary();
  end
endmodule